// File: doc/BRIEF.md
# USB Debug Port Access Scheduler

This block sits between a small register-style request interface used by debug software and the transaction engine of one fixed high-speed USB 2.0 root port. Software loads one request and sets a go bit. The request is either an OUT transfer with up to eight payload bytes or an IN transfer. The block waits until the current microframe still has its access token and the port and power conditions allow traffic. It then launches exactly one transaction. When the engine reports completion, the block returns the status, and for IN transfers the received bytes.

The block has its own request and completion handshake, so no host controller driver needs to run. It takes no port-enable input, so clearing the port's normal enable has no effect on it. A transaction that fails is still completed and its error is reported; it is never retried.

Top module: `usb_dbg_sched`

## Requirements
- R1: Every launched transaction is addressed to root port `DBG_PORT` (default 1), and no other port value ever appears on `xact_port`.
- R2: At most one transaction starts between two consecutive `sof_pulse` cycles. A second request accepted inside the same microframe launches only after the next `sof_pulse`.
- R3: After reset no transaction starts until the first `sof_pulse` has been seen. Each `sof_pulse` re-arms one access token, and a launch consumes it.
- R4: A pending request does not start while `port_suspended` is 1 or `ctrl_in_d0` is 0. It stays pending, with `go` at 1, and it starts once both conditions allow it.
- R5: While `port_in_reset` is 1, no transaction starts. A pending request is held until the reset ends.
- R6: The edge that samples `eng_done` high during a transaction sets `done` and clears `go`. At that edge, `err` becomes 1 exactly when `eng_status` is non-zero, and `err_code` takes `eng_status`. The status codes are: 00 success, 01 timeout, 10 bad handshake, 11 data error. A failed transaction is never started again.
- R7: On completion of an IN request (`sw_dir`=1), `rdata` captures `eng_rdata`. On completion of an OUT request (`sw_dir`=0), `rdata` keeps its previous value.
- R8: A write made while `go` is 1 is ignored. The launched direction, length and data are those of the accepted request.
- R9: `xact_start` is a single-cycle pulse. It is combinational with the launch condition, and it carries the accepted direction, data, and a byte count clamped to `MAX_BYTES`, so lengths 9 to 15 launch as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_pulse | input | 1 | One-cycle microframe start strobe |
| port_suspended | input | 1 | Debug port is suspended |
| port_in_reset | input | 1 | Port is driving a bus reset |
| ctrl_in_d0 | input | 1 | Host controller is in full-power state |
| sw_wr | input | 1 | Software request register write strobe |
| sw_go | input | 1 | Go bit in the written value |
| sw_dir | input | 1 | 1 = IN request, 0 = OUT request |
| sw_len | input | 4 | Byte count, 0 to 8 |
| sw_wdata | input | 64 | OUT payload, byte 0 in bits 7:0 |
| go | output | 1 | Request pending or in flight |
| done | output | 1 | Last request completed |
| err | output | 1 | Last request ended with bad status |
| err_code | output | 2 | Status of the last completion |
| rdata | output | 64 | Bytes received by the last IN request |
| xact_start | output | 1 | Launch strobe to the transaction engine |
| xact_port | output | 4 | Root port number of the launched transaction |
| xact_dir | output | 1 | Direction of the launched transaction |
| xact_len | output | 4 | Byte count of the launched transaction |
| xact_data | output | 64 | OUT payload of the launched transaction |
| eng_done | input | 1 | Completion strobe from the engine |
| eng_status | input | 2 | Completion status from the engine |
| eng_rdata | input | 64 | Received bytes from the engine |

## Verification
Each result has a fixed arrival time:

- `go` rises at the clock edge that accepts the write.
- `xact_start` is high in the same cycle in which pending request, token and gates all hold, so it can appear in the cycle right after the accepting edge.
- `done`, `err`, `err_code` and `rdata` change at the single edge that samples `eng_done`.

The bench drives all inputs and samples all outputs on the falling edge. It checks the pending state one falling edge after the write. It scans each cycle for the launch strobe and checks the completion fields one falling edge after it raises `eng_done`. Each launch is tagged with a microframe count kept in the bench, so the separation between microframes is checked arithmetically.

// File: rtl/usb_dbg_sched.sv
module usb_dbg_sched #(
  parameter int PORT_W    = 4,
  parameter int DBG_PORT  = 1,
  parameter int MAX_BYTES = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W   = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_pulse,
  input  logic              port_suspended,
  input  logic              port_in_reset,
  input  logic              ctrl_in_d0,
  input  logic              sw_wr,
  input  logic              sw_go,
  input  logic              sw_dir,
  input  logic [LEN_W-1:0]  sw_len,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic              go,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code,
  output logic [DATA_W-1:0] rdata,
  output logic              xact_start,
  output logic [PORT_W-1:0] xact_port,
  output logic              xact_dir,
  output logic [LEN_W-1:0]  xact_len,
  output logic [DATA_W-1:0] xact_data,
  input  logic              eng_done,
  input  logic [1:0]        eng_status,
  input  logic [DATA_W-1:0] eng_rdata
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BYTES);

  logic pend, busy, token;

  wire accept  = sw_wr && sw_go && !go;
  wire may_run = !port_suspended && ctrl_in_d0 && !port_in_reset;
  wire finish  = busy && eng_done;

  assign go         = pend || busy;
  assign xact_start = pend && token && may_run;
  assign xact_port  = PORT_W'(DBG_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      busy      <= 1'b0;
      token     <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= 2'b00;
      rdata     <= '0;
      xact_dir  <= 1'b0;
      xact_len  <= '0;
      xact_data <= '0;
    end else begin
      if (sof_pulse)       token <= 1'b1;
      else if (xact_start) token <= 1'b0;

      if (accept) begin
        pend      <= 1'b1;
        done      <= 1'b0;
        err       <= 1'b0;
        err_code  <= 2'b00;
        xact_dir  <= sw_dir;
        xact_len  <= (sw_len > LEN_MAX) ? LEN_MAX : sw_len;
        xact_data <= sw_wdata;
      end

      if (xact_start) begin
        pend <= 1'b0;
        busy <= 1'b1;
      end

      if (finish) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        err      <= |eng_status;
        err_code <= eng_status;
        if (xact_dir) rdata <= eng_rdata;
      end
    end
  end

  // microframe occupancy tracker used only by the checks below
  logic chk_used;
  always_ff @(posedge clk) begin
    if (!rst_n)          chk_used <= 1'b0;
    else if (sof_pulse)  chk_used <= 1'b0;
    else if (xact_start) chk_used <= 1'b1;
  end

  assert_one_per_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_used && !sof_pulse |-> !xact_start);

  assert_gated_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |-> !port_suspended && ctrl_in_d0);

  assert_no_start_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |-> !port_in_reset);

  assert_done_on_completion_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done |=> done && !go);

  assert_no_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && eng_done |=> !xact_start);

  assert_ignore_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go && sw_wr |=> $stable(xact_data) && $stable(xact_len) && $stable(xact_dir));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |=> !xact_start);

  assert_len_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xact_start |-> xact_len <= LEN_MAX);

endmodule

// File: tb/usb_dbg_sched_tb.sv
module usb_dbg_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_pulse = 1'b0, port_suspended = 1'b0, port_in_reset = 1'b0, ctrl_in_d0 = 1'b1;
  logic sw_wr = 1'b0, sw_go = 1'b0, sw_dir = 1'b0;
  logic [3:0] sw_len = '0;
  logic [63:0] sw_wdata = '0;
  logic go, done, err, xact_start, xact_dir;
  logic [1:0] err_code;
  logic [63:0] rdata, xact_data;
  logic [3:0] xact_port, xact_len;
  logic eng_done = 1'b0;
  logic [1:0] eng_status = '0;
  logic [63:0] eng_rdata = '0;

  int total = 0, bad = 0, frame = 0, last_tag = -1, cycles = 0;
  logic [63:0] exp_rdata = '0;

  usb_dbg_sched u_dut (
    .clk(clk), .rst_n(rst_n), .sof_pulse(sof_pulse), .port_suspended(port_suspended),
    .port_in_reset(port_in_reset), .ctrl_in_d0(ctrl_in_d0), .sw_wr(sw_wr), .sw_go(sw_go),
    .sw_dir(sw_dir), .sw_len(sw_len), .sw_wdata(sw_wdata), .go(go), .done(done), .err(err),
    .err_code(err_code), .rdata(rdata), .xact_start(xact_start), .xact_port(xact_port),
    .xact_dir(xact_dir), .xact_len(xact_len), .xact_data(xact_data), .eng_done(eng_done),
    .eng_status(eng_status), .eng_rdata(eng_rdata));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && sof_pulse) frame <= frame + 1;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cycles == 150000);
    bad++; total++;
    $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
    summary();
  end

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      sof_pulse = rst_n && (ph == 9);
      ph = (ph == 15) ? 0 : ph + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write_req(input logic dir, input logic [3:0] len, input logic [63:0] data);
    sw_wr = 1'b1; sw_go = 1'b1; sw_dir = dir; sw_len = len; sw_wdata = data;
    @(negedge clk);
    sw_wr = 1'b0; sw_go = 1'b0;
  endtask

  task automatic wait_launch(input int limit, output int tag);
    tag = -1;
    for (int i = 0; i < limit; i++) begin
      if (xact_start) begin tag = frame; return; end
      @(negedge clk);
    end
  endtask

  task automatic complete(input logic dir, input logic [1:0] st, input logic [63:0] rd);
    @(negedge clk);
    eng_done = 1'b1; eng_status = st; eng_rdata = rd;
    @(negedge clk);
    eng_done = 1'b0;
    if (dir) exp_rdata = rd;
    chk(done === 1'b1 && go === 1'b0, "R6 done/go", {62'd0, done, go}, 64'h2);
    chk(err === (st != 0) && err_code === st, "R6 err/code", {61'd0, err, err_code}, {61'd0, st != 0, st});
    chk(rdata === exp_rdata, "R7 rdata", rdata, exp_rdata);
    chk(xact_start === 1'b0, "R6 no retry", {63'd0, xact_start}, 64'd0);
  endtask

  task automatic full_xact(input logic dir, input logic [3:0] len, input logic [63:0] data,
                           input logic [1:0] st, input logic [63:0] rd);
    int tag;
    logic [3:0] elen;
    elen = (len > 8) ? 4'd8 : len;
    write_req(dir, len, data);
    chk(go === 1'b1, "R4 go pending", {63'd0, go}, 64'd1);
    wait_launch(60, tag);
    chk(tag >= 0, "R2 launch seen", 64'(tag), 64'd0);
    chk(tag > last_tag, "R2 one per microframe", 64'(tag), 64'(last_tag + 1));
    chk(xact_port === 4'd1, "R1 port", {60'd0, xact_port}, 64'd1);
    chk(xact_dir === dir && xact_len === elen, "R9 dir/len", {59'd0, xact_dir, xact_len}, {59'd0, dir, elen});
    chk(xact_data === data, "R9 data", xact_data, data);
    last_tag = tag;
    complete(dir, st, rd);
  endtask

  initial begin
    int tag, t1;
    logic [63:0] d;
    repeat (3) @(negedge clk);
    chk(go === 0 && done === 0 && err === 0 && xact_start === 0, "reset state",
        {60'd0, go, done, err, xact_start}, 64'd0);
    rst_n = 1'b1;
    // R3: request right after reset must wait for the first microframe strobe
    write_req(1'b0, 4'd3, 64'h1122334455667788);
    wait_launch(60, tag);
    chk(tag >= 1, "R3 first token after sof", 64'(tag), 64'd1);
    last_tag = tag;
    complete(1'b0, 2'd0, 64'd0);

    // near-exhaustive sweep: direction x length x status
    for (int dir = 0; dir < 2; dir++)
      for (int len = 0; len < 16; len++)
        for (int st = 0; st < 4; st++) begin
          d = 64'h0123456789ABCDEF ^ (64'(dir * 64 + len * 4 + st) * 64'h9E3779B97F4A7C15);
          full_xact(dir[0], len[3:0], d, st[1:0], ~d);
        end

    // R2: back-to-back requests land in consecutive microframes
    write_req(1'b0, 4'd1, 64'hAA);
    wait_launch(60, t1);
    complete(1'b0, 2'd0, 64'd0);
    write_req(1'b0, 4'd2, 64'hBB);
    chk(xact_start === 1'b0, "R2 second held in frame", {63'd0, xact_start}, 64'd0);
    wait_launch(60, tag);
    chk(tag == t1 + 1, "R2 next microframe", 64'(tag), 64'(t1 + 1));
    complete(1'b0, 2'd2, 64'd0);
    last_tag = tag;

    // R8: write while go is set is ignored
    write_req(1'b1, 4'd4, 64'hCAFE0000CAFE0000);
    write_req(1'b0, 4'd7, 64'h5555555555555555);
    wait_launch(60, tag);
    chk(xact_data === 64'hCAFE0000CAFE0000 && xact_dir === 1'b1 && xact_len === 4'd4,
        "R8 busy write ignored", xact_data, 64'hCAFE0000CAFE0000);
    complete(1'b1, 2'd1, 64'h77);
    last_tag = tag;

    // R4/R5: each gate holds the request across several microframes
    for (int g = 0; g < 3; g++) begin
      if (g == 0) port_suspended = 1'b1;
      if (g == 1) ctrl_in_d0 = 1'b0;
      if (g == 2) port_in_reset = 1'b1;
      write_req(1'b0, 4'd5, 64'(g + 100));
      wait_launch(40, tag);
      chk(tag < 0, (g == 2) ? "R5 held in bus reset" : "R4 held by gate", 64'(tag), 64'hFFFFFFFFFFFFFFFF);
      chk(go === 1'b1, (g == 2) ? "R5 still pending" : "R4 still pending", {63'd0, go}, 64'd1);
      port_suspended = 1'b0; ctrl_in_d0 = 1'b1; port_in_reset = 1'b0;
      #1;
      wait_launch(5, tag);
      chk(tag >= 0 && xact_data === 64'(g + 100), (g == 2) ? "R5 released" : "R4 released",
          xact_data, 64'(g + 100));
      complete(1'b0, 2'd3, 64'd0);
      last_tag = tag;
    end
    summary();
  end
endmodule